// File: doc/BRIEF.md
# Physical Register Free List

This block hands out physical register indices to the rename stage of an out-of-order core. Every cycle, each of several rename lanes may ask for a fresh physical register. The block answers each lane with a grant flag and an index, taken in lane order from a circular pool of free indices. Commit lanes return the index that an instruction's destination used to map to, and those indices go back into the pool in order.

Any lane may record a checkpoint of the allocation position under a branch tag. A misprediction redirect then restores that position, so every index handed out after the branch becomes free again. An exception or pipeline flush goes further and rewinds the allocation position to the committed position. The committed position moves forward by one for every returned register. A lane whose destination is architectural register zero never consumes an index and always receives index 0.

The control is a two-state machine. `FL_FILL` is entered at reset. In it, one pool slot per cycle is loaded with the indices that are not reserved for the initial architectural mapping. The transition *fill done* fires when the last slot has been written and moves to `FL_RUN`, where allocation, return, checkpoint and recovery take place. `FL_RUN` has one transition, *stay*. Redirect and flush act inside it without a state change.

Top module: `phys_free_list`

## Requirements
- R1: After reset, `can_alloc` is 0 on every lane for POOL = NUM_PREGS − NUM_AREGS cycles (state `FL_FILL`). After that, the pool holds indices NUM_AREGS … NUM_PREGS−1 and gives them out in ascending order.
- R2: A lane that is not a zero-destination lane shows `can_alloc` = 1 only in `FL_RUN`, with no redirect or flush that cycle, and only when the free count is at least one more than the number of requesting lanes below it.
- R3: A requesting lane receives the pool entry at the allocation position plus the number of requesting lanes below it. The allocation position advances by the number of granted lanes.
- R4: A lane with `zero_dst` = 1 shows `alloc_idx` = 0 and `can_alloc` equal to the run condition of R2. It consumes no entry and is not counted as a requester.
- R5: Returned indices are appended to the pool in lane order. They are handed out only after every entry that was already free. Returns are not presented during `FL_FILL`.
- R6: A lane with `cp_valid` in a run cycle stores, under its tag, the allocation position after the grants of that lane and all lanes below it. When several lanes use one tag, the highest lane's value is kept.
- R7: `redirect_valid` forces `can_alloc` to 0 in that cycle and sets the allocation position to the value stored under `redirect_tag`. The indices given out after that checkpoint are handed out again.
- R8: `flush` forces `can_alloc` to 0 and sets the allocation position to the committed position, including the returns of that cycle. Flush takes priority over a simultaneous redirect.
- R9: The free count never exceeds POOL.
- R10: Checkpoint writes presented in a redirect or flush cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | LANES | Lane wants a new physical register |
| zero_dst | input | LANES | Lane's destination is architectural register zero |
| can_alloc | output | LANES | Lane's request can be granted this cycle |
| alloc_idx | output | LANES*IDX_W | Index offered to each lane, lane k at bits k*IDX_W |
| cp_valid | input | LANES | Lane records a checkpoint |
| cp_tag | input | LANES*TAG_W | Branch tag of each lane's checkpoint |
| redirect_valid | input | 1 | Misprediction rollback request |
| redirect_tag | input | TAG_W | Tag whose checkpoint is restored |
| flush | input | 1 | Exception or pipeline flush |
| free_req | input | LANES | Commit lane returns a register |
| free_idx | input | LANES*IDX_W | Index returned by each commit lane |

## Verification
The bench builds the block with three lanes, twelve physical registers, six reserved architectural mappings and four tags. With these values the fill lasts six cycles, and the pool runs dry after two full-width allocations. This makes both the empty-pool refusal and the partial grant on the last lane easy to reach. The pool depth of sixteen against a live span of six makes the ring wrap within the run. Checkpoint, redirect and flush each move the allocation position back across that wrap, and their results are told apart by the distinct index values returned.

// File: rtl/frl_pkg.sv
package frl_pkg;

    // Operating phase of the free list
    typedef enum logic [0:0] {
        FL_FILL = 1'b0,   // loading the initial pool one slot per cycle
        FL_RUN  = 1'b1    // allocation, return and recovery active
    } fl_state_e;

endpackage

// File: rtl/frl_ctrl.sv
module frl_ctrl
    import frl_pkg::*;
#(
    parameter int POOL  = 32,
    parameter int BASE  = 32,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    output fl_state_e        state,
    output logic             fill_we,
    output logic [IDX_W-1:0] fill_slot,
    output logic [IDX_W-1:0] fill_val
);

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(POOL - 1);

    fl_state_e        state_q, state_d;
    logic [IDX_W-1:0] fill_cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_FILL;
        else        state_q <= state_d;
    end

    // fill slot counter
    always_ff @(posedge clk) begin
        if (!rst_n)                fill_cnt <= '0;
        else if (state_q == FL_FILL) fill_cnt <= fill_cnt + 1'b1;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_FILL: if (fill_cnt == LAST_SLOT) state_d = FL_RUN;   // fill done
            FL_RUN:  state_d = FL_RUN;                              // stay
            default: state_d = FL_FILL;
        endcase
    end

    // outputs
    always_comb begin
        fill_we   = 1'b0;
        fill_slot = fill_cnt;
        fill_val  = IDX_W'(BASE) + fill_cnt;
        unique case (state_q)
            FL_FILL: fill_we = 1'b1;
            FL_RUN:  fill_we = 1'b0;
            default: fill_we = 1'b0;
        endcase
    end

    assign state = state_q;

    AST_FILL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_FILL && fill_cnt == LAST_SLOT) |=> (state_q == FL_RUN)); // R1

endmodule

// File: rtl/frl_grant.sv
module frl_grant #(
    parameter int LANES = 4,
    parameter int IDX_W = 6,
    parameter int PTR_W = 7
) (
    input  logic [LANES-1:0]             alloc_req,
    input  logic [LANES-1:0]             zero_dst,
    input  logic                         run_en,
    input  logic [PTR_W-1:0]             free_cnt,
    output logic [LANES-1:0]             can_alloc,
    output logic [LANES-1:0][IDX_W-1:0]  req_off,
    output logic [LANES-1:0][PTR_W-1:0]  grant_incl,
    output logic [PTR_W-1:0]             n_grant
);

    // Lane chain: each lane sees how many lanes below it asked for an entry
    always_comb begin
        logic [PTR_W-1:0] acc_req;
        logic [PTR_W-1:0] acc_grant;
        logic             wants;
        acc_req   = '0;
        acc_grant = '0;
        for (int k = 0; k < LANES; k++) begin
            wants      = alloc_req[k] && !zero_dst[k];
            req_off[k] = IDX_W'(acc_req);
            if (zero_dst[k]) can_alloc[k] = run_en;
            else             can_alloc[k] = run_en && (free_cnt > acc_req);
            if (wants)                acc_req   = acc_req + 1'b1;
            if (wants && can_alloc[k]) acc_grant = acc_grant + 1'b1;
            grant_incl[k] = acc_grant;
        end
        n_grant = acc_grant;
    end

endmodule

// File: rtl/frl_ckpt.sv
module frl_ckpt #(
    parameter int LANES    = 4,
    parameter int NUM_TAGS = 16,
    parameter int TAG_W    = 4,
    parameter int PTR_W    = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES-1:0]             wr_en,
    input  logic [LANES-1:0][TAG_W-1:0]  wr_tag,
    input  logic [LANES-1:0][PTR_W-1:0]  wr_val,
    input  logic [TAG_W-1:0]             rd_tag,
    output logic [PTR_W-1:0]             rd_val
);

    logic [PTR_W-1:0] slot [NUM_TAGS];

    // later lanes overwrite earlier ones on the same tag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_TAGS; t++) slot[t] <= '0;
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (wr_en[k]) slot[wr_tag[k]] <= wr_val[k];
            end
        end
    end

    assign rd_val = slot[rd_tag];

    AST_CKPT_LAST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[LANES-1] |=> (slot[$past(wr_tag[LANES-1])] == $past(wr_val[LANES-1]))); // R6

endmodule

// File: rtl/phys_free_list.sv
module phys_free_list
    import frl_pkg::*;
#(
    parameter  int LANES     = 4,
    parameter  int NUM_PREGS = 64,
    parameter  int NUM_AREGS = 32,
    parameter  int NUM_TAGS  = 16,
    localparam int IDX_W     = $clog2(NUM_PREGS),
    localparam int TAG_W     = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         alloc_req,
    input  logic [LANES-1:0]         zero_dst,
    output logic [LANES-1:0]         can_alloc,
    output logic [LANES*IDX_W-1:0]   alloc_idx,
    input  logic [LANES-1:0]         cp_valid,
    input  logic [LANES*TAG_W-1:0]   cp_tag,
    input  logic                     redirect_valid,
    input  logic [TAG_W-1:0]         redirect_tag,
    input  logic                     flush,
    input  logic [LANES-1:0]         free_req,
    input  logic [LANES*IDX_W-1:0]   free_idx
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int PTR_W = IDX_W + 1;
    localparam int POOL  = NUM_PREGS - NUM_AREGS;

    fl_state_e        state;
    logic             fill_we;
    logic [IDX_W-1:0] fill_slot, fill_val;

    logic [PTR_W-1:0] head_q, tail_q, commit_q;
    logic [PTR_W-1:0] free_cnt, n_grant, n_free, ck_rd;
    logic             run_ok;

    logic [LANES-1:0][IDX_W-1:0] req_off, free_off;
    logic [LANES-1:0][PTR_W-1:0] grant_incl, ck_val;
    logic [LANES-1:0][TAG_W-1:0] ck_tag;
    logic [LANES-1:0]            ck_we;

    logic [IDX_W-1:0] ring [DEPTH];

    frl_ctrl #(.POOL(POOL), .BASE(NUM_AREGS), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .state(state),
        .fill_we(fill_we), .fill_slot(fill_slot), .fill_val(fill_val)
    );

    assign run_ok   = (state == FL_RUN) && !redirect_valid && !flush;
    assign free_cnt = tail_q - head_q;

    frl_grant #(.LANES(LANES), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_grant (
        .alloc_req(alloc_req), .zero_dst(zero_dst), .run_en(run_ok),
        .free_cnt(free_cnt), .can_alloc(can_alloc), .req_off(req_off),
        .grant_incl(grant_incl), .n_grant(n_grant)
    );

    // per-lane views of flat ports
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [IDX_W-1:0] rd_slot;
        assign rd_slot   = head_q[IDX_W-1:0] + req_off[k];
        assign alloc_idx[k*IDX_W +: IDX_W] = zero_dst[k] ? '0 : ring[rd_slot];
        assign ck_tag[k] = cp_tag[k*TAG_W +: TAG_W];
        assign ck_val[k] = head_q + grant_incl[k];
        assign ck_we[k]  = cp_valid[k] && run_ok;

        AST_GRANT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            (can_alloc[k] && alloc_req[k] && !zero_dst[k] && k > 0)
                |-> (can_alloc[(k > 0) ? k-1 : 0] || !alloc_req[(k > 0) ? k-1 : 0]
                     || zero_dst[(k > 0) ? k-1 : 0])); // R2
    end

    frl_ckpt #(.LANES(LANES), .NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W), .PTR_W(PTR_W)) u_ckpt (
        .clk(clk), .rst_n(rst_n), .wr_en(ck_we), .wr_tag(ck_tag),
        .wr_val(ck_val), .rd_tag(redirect_tag), .rd_val(ck_rd)
    );

    // returned registers land at the tail in lane order
    always_comb begin
        logic [IDX_W-1:0] acc;
        acc = '0;
        for (int k = 0; k < LANES; k++) begin
            free_off[k] = acc;
            if (free_req[k]) acc = acc + 1'b1;
        end
        n_free = PTR_W'(acc);
    end

    always_ff @(posedge clk) begin
        if (fill_we) ring[fill_slot] <= fill_val;
        for (int k = 0; k < LANES; k++) begin
            if (free_req[k])
                ring[tail_q[IDX_W-1:0] + free_off[k]] <= free_idx[k*IDX_W +: IDX_W];
        end
    end

    // pool pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q   <= '0;
            tail_q   <= PTR_W'(POOL);
            commit_q <= '0;
        end else begin
            tail_q   <= tail_q + n_free;
            commit_q <= commit_q + n_free;
            if (flush)               head_q <= commit_q + n_free;
            else if (redirect_valid) head_q <= ck_rd;
            else                     head_q <= head_q + n_grant;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= PTR_W'(POOL)); // R9
    AST_QUIET_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FL_FILL) |-> (can_alloc == '0)); // R1
    AST_QUIET_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid || flush) |-> (can_alloc == '0)); // R7
    AST_FLUSH_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (head_q == commit_q)); // R8
    AST_REDIRECT_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !flush) |=> (head_q == $past(ck_rd))); // R7
    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run_ok |=> (head_q == $past(head_q) + $past(n_grant))); // R3
    AST_NO_FREE_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FL_FILL) |-> (free_req == '0)); // R5

endmodule

// File: tb/tb_phys_free_list.sv
module tb_phys_free_list;

    localparam int L     = 3;
    localparam int NP    = 12;
    localparam int NA    = 6;
    localparam int NT    = 4;
    localparam int IW    = 4;
    localparam int TW    = 2;
    localparam int POOL  = NP - NA;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [L-1:0]    alloc_req = '0, zero_dst = '0, cp_valid = '0, free_req = '0;
    logic [L-1:0]    can_alloc;
    logic [L*IW-1:0] alloc_idx;
    logic [L*TW-1:0] cp_tag = '0;
    logic [L*IW-1:0] free_idx = '0;
    logic            redirect_valid = 1'b0, flush = 1'b0;
    logic [TW-1:0]   redirect_tag = '0;

    phys_free_list #(.LANES(L), .NUM_PREGS(NP), .NUM_AREGS(NA), .NUM_TAGS(NT)) dut (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .zero_dst(zero_dst),
        .can_alloc(can_alloc), .alloc_idx(alloc_idx), .cp_valid(cp_valid),
        .cp_tag(cp_tag), .redirect_valid(redirect_valid), .redirect_tag(redirect_tag),
        .flush(flush), .free_req(free_req), .free_idx(free_idx)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // reference pool model
    int mq [64];
    int mck [NT];
    int mh, mt, mc, fill_edges;

    // stimulus for one cycle
    logic [L-1:0] b_req, b_zero, b_cp, b_free;
    int b_cpt [L];
    int b_fidx [L];
    logic b_redir, b_flush;
    int b_rtag;

    task automatic clear();
        b_req = '0; b_zero = '0; b_cp = '0; b_free = '0;
        b_redir = 1'b0; b_flush = 1'b0; b_rtag = 0;
        for (int k = 0; k < L; k++) begin b_cpt[k] = 0; b_fidx[k] = 0; end
    endtask

    task automatic chk(input string tag, input string what, input int lane,
                       input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s lane %0d: got %0d expected %0d", tag, what, lane, got, exp);
        end
    endtask

    // drive one cycle at a falling edge, check, advance the model
    task automatic step(input string tag);
        int pre, ng, e_idx;
        int gi [L];
        bit run, e_can;
        alloc_req = b_req; zero_dst = b_zero; cp_valid = b_cp; free_req = b_free;
        redirect_valid = b_redir; redirect_tag = TW'(b_rtag); flush = b_flush;
        for (int k = 0; k < L; k++) begin
            cp_tag[k*TW +: TW]   = TW'(b_cpt[k]);
            free_idx[k*IW +: IW] = IW'(b_fidx[k]);
        end
        #2;
        run = (fill_edges >= POOL) && !b_redir && !b_flush;
        pre = 0; ng = 0;
        for (int k = 0; k < L; k++) begin
            if (b_zero[k]) begin
                e_can = run;
                chk(tag, "can_alloc", k, int'(can_alloc[k]), int'(e_can));
                if (e_can) chk(tag, "alloc_idx", k, int'(alloc_idx[k*IW +: IW]), 0);
            end else begin
                e_can = run && ((mt - mh) >= pre + 1);
                chk(tag, "can_alloc", k, int'(can_alloc[k]), int'(e_can));
                if (b_req[k]) begin
                    e_idx = mq[(mh + pre) % 64];
                    if (e_can) begin
                        chk(tag, "alloc_idx", k, int'(alloc_idx[k*IW +: IW]), e_idx);
                        ng++;
                    end
                    pre++;
                end
            end
            gi[k] = ng;
        end
        if (run)
            for (int k = 0; k < L; k++) if (b_cp[k]) mck[b_cpt[k]] = mh + gi[k];
        for (int k = 0; k < L; k++)
            if (b_free[k]) begin mq[mt % 64] = b_fidx[k]; mt++; mc++; end
        if (b_flush)      mh = mc;
        else if (b_redir) mh = mck[b_rtag];
        else              mh = mh + ng;
        @(negedge clk);
        fill_edges++;
    endtask

    task automatic do_free(input string tag, input logic [L-1:0] m,
                           input int a, input int b, input int c);
        clear(); b_free = m; b_fidx[0] = a; b_fidx[1] = b; b_fidx[2] = c;
        step(tag);
    endtask

    task automatic do_alloc(input string tag, input logic [L-1:0] m);
        clear(); b_req = m; step(tag);
    endtask

    // R1: quiet fill after reset, then ascending initial pool
    task automatic t_reset_fill();
        for (int i = 0; i < POOL; i++) do_alloc("R1", 3'b111);
        do_alloc("R1", 3'b111);                 // expect 6,7,8
    endtask

    // R2 R3 R5: in-order grants, exhaustion, partial grant, FIFO reuse
    task automatic t_alloc_order();
        do_alloc("R3", 3'b111);                 // 9,10,11
        do_alloc("R2", 3'b001);                 // empty pool
        do_free("R5", 3'b011, 0, 1, 0);
        do_alloc("R5", 3'b111);                 // 0,1 then lane 2 refused (R2)
    endtask

    // R4: zero-destination lanes
    task automatic t_zero_dst();
        do_free("R5", 3'b111, 2, 3, 4);
        clear(); b_zero = 3'b001; b_req = 3'b010; step("R4");
        clear(); b_zero = 3'b010; b_req = 3'b101; step("R4");
    endtask

    // R6 R7: checkpoint then misprediction rollback
    task automatic t_redirect();
        do_free("R7", 3'b111, 5, 6, 7);
        clear(); b_req = 3'b111; b_cp = 3'b010; b_cpt[1] = 2; step("R6");
        do_free("R7", 3'b011, 8, 9, 0);
        do_alloc("R7", 3'b011);
        clear(); b_req = 3'b111; b_redir = 1'b1; b_rtag = 2; step("R7");
        do_alloc("R7", 3'b111);                 // rolled-back indices again
    endtask

    // R6: highest lane wins on a shared tag
    task automatic t_ckpt_last();
        do_free("R6", 3'b111, 10, 11, 0);
        clear(); b_req = 3'b111; b_cp = 3'b101; b_cpt[0] = 1; b_cpt[2] = 1; step("R6");
        do_free("R6", 3'b111, 1, 2, 3);
        do_alloc("R6", 3'b111);
        clear(); b_redir = 1'b1; b_rtag = 1; step("R6");
        do_alloc("R6", 3'b001);
    endtask

    // R10: checkpoint write during a redirect cycle is dropped
    task automatic t_cp_blocked();
        clear(); b_redir = 1'b1; b_rtag = 1; b_cp = 3'b001; b_cpt[0] = 1; step("R10");
        do_alloc("R10", 3'b001);
        clear(); b_redir = 1'b1; b_rtag = 1; step("R10");
        do_alloc("R10", 3'b001);
    endtask

    // R8 R9: flush to committed position, priority over redirect, full pool
    task automatic t_flush();
        clear(); b_flush = 1'b1; b_req = 3'b111; b_free = 3'b001; b_fidx[0] = 4; step("R8");
        do_alloc("R8", 3'b111);
        clear(); b_flush = 1'b1; b_redir = 1'b1; b_rtag = 1; step("R8");
        do_alloc("R8", 3'b001);
        do_alloc("R9", 3'b111);
        do_alloc("R9", 3'b111);                 // lane 2 refused: pool never above POOL
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mq[i] = 0;
        for (int t = 0; t < NT; t++) mck[t] = 0;
        for (int i = 0; i < POOL; i++) mq[i] = NA + i;
        mh = 0; mt = POOL; mc = 0; fill_edges = 0;
        clear();
        repeat (3) @(negedge clk);
        chk("R1", "reset can_alloc", 0, int'(can_alloc), 0);
        rst_n = 1'b1;
        t_reset_fill();
        t_alloc_order();
        t_zero_dst();
        t_redirect();
        t_ckpt_last();
        t_cp_blocked();
        t_flush();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: got no completion expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule